// File: doc/BRIEF.md
# Downward-Growing Stack Pointer Unit

This block holds the stack pointer of an 8-bit processor core that has 2 KB of data SRAM. The stack grows toward lower addresses. The pointer always marks the next free location at the top of the stack. Software sees the pointer as two byte-wide registers on the core's register bus and can read or load either byte at any time.

Each cycle the core may request one of four stack operations:
- a single-byte push,
- a single-byte pop,
- a two-byte call entry (also used for interrupt entry),
- a two-byte return.

For each request the unit drives the SRAM addresses to use in that same cycle, marks whether they are written or read, and moves the pointer by one or two. Only the low 12 bits of the pointer are held. The upper four bits always read as zero. Pointer arithmetic wraps within those 12 bits. The SRAM and the ordering of return-address bytes on the data path are outside this block.

Top module: `stack_ptr_unit`

## Requirements
- R1: Once reset has been released, the pointer reads 0x04FF and no stack access is flagged (acc_en low).
- R2: A push (op code 1) drives acc_addr0 equal to the current pointer with acc_wr high. The pointer is one lower on the following cycle.
- R3: A pop (op code 2) drives acc_addr0 equal to the current pointer plus one with acc_wr low. The pointer takes that same value on the following cycle.
- R4: A call entry (op code 3) drives acc_addr0 (low byte) at the current pointer and acc_addr1 (high byte) at the pointer minus one. acc_wr and acc_pair are high, and the pointer drops by two on the next cycle.
- R5: A return (op code 4) drives acc_addr1 (high byte) at the pointer plus one and acc_addr0 (low byte) at the pointer plus two. acc_pair is high and acc_wr is low, and the pointer rises by two on the next cycle.
- R6: Bits 15..12 of the pointer, of every access address and of the high-byte read data are always zero. Writes to those bits are ignored, and all pointer arithmetic wraps modulo 4096.
- R7: The low byte of the pointer is at bus address 0x5D and the high byte is at 0x5E. bus_rdata combinationally returns the addressed byte. A write with bus_we high loads that byte on the next clock edge.
- R8: A register-bus write to 0x5D or 0x5E takes priority over a stack operation in the same cycle. The pointer takes the written value and the operation's step is discarded.
- R9: With op code 0 (or any undefined code 5..7) the pointer holds and acc_en is low. A bus write to any address other than 0x5D or 0x5E leaves the pointer unchanged, and reads of such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 3 | Stack operation: 0 none, 1 push, 2 pop, 3 call entry, 4 return |
| bus_addr | input | 16 | Register-bus data address |
| bus_wdata | input | 8 | Register-bus write data |
| bus_we | input | 1 | Register-bus write strobe |
| bus_rdata | output | 8 | Register-bus read data for the addressed pointer byte |
| sp | output | 16 | Current stack pointer |
| acc_addr0 | output | 16 | SRAM address of the single byte, or of the low byte of a pair |
| acc_addr1 | output | 16 | SRAM address of the high byte of a pair |
| acc_en | output | 1 | A stack access is requested this cycle |
| acc_wr | output | 1 | The access writes SRAM (push, call) rather than reads |
| acc_pair | output | 1 | The access covers two bytes (call, return) |

## Verification
The embedded assertions check the following on every clocked cycle:
- the one-step and two-step pointer moves for push, pop, call and return,
- the hold when idle,
- the precedence of a bus write over a stack step,
- the zero upper nibble,
- the adjacency of the two addresses of a pair.

Only the directed scenarios can show the rest:
- the exact access addresses against a known pointer, including the wrap at 0x000 and 0xFFF,
- back-to-back pushes,
- read data on both byte addresses,
- that a write to a neighbouring bus address leaves the pointer alone.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4
  } sp_op_e;
endpackage

// File: rtl/sp_adjust.sv
module sp_adjust #(
  parameter int IMPL_W = 12
) (
  input  sp_pkg::sp_op_e     op_i,
  input  logic [IMPL_W-1:0]  sp_cur,
  output logic [IMPL_W-1:0]  sp_step,
  output logic [IMPL_W-1:0]  addr0,
  output logic [IMPL_W-1:0]  addr1,
  output logic               en,
  output logic               wr,
  output logic               pair
);
  import sp_pkg::*;

  localparam logic [IMPL_W-1:0] ONE = IMPL_W'(1);
  localparam logic [IMPL_W-1:0] TWO = IMPL_W'(2);

  // Arithmetic is IMPL_W bits wide, so it wraps modulo 2**IMPL_W (R6).
  always_comb begin
    sp_step = sp_cur;
    addr0   = sp_cur;
    addr1   = sp_cur;
    en      = 1'b0;
    wr      = 1'b0;
    pair    = 1'b0;
    case (op_i)
      OP_PUSH: begin            // R2: store at top, then move down
        sp_step = sp_cur - ONE;
        en      = 1'b1;
        wr      = 1'b1;
      end
      OP_POP: begin             // R3: move up, then load
        addr0   = sp_cur + ONE;
        sp_step = sp_cur + ONE;
        en      = 1'b1;
      end
      OP_CALL: begin            // R4: low byte at SP, high byte below it
        addr1   = sp_cur - ONE;
        sp_step = sp_cur - TWO;
        en      = 1'b1;
        wr      = 1'b1;
        pair    = 1'b1;
      end
      OP_RET: begin             // R5: high byte at SP+1, low byte at SP+2
        addr0   = sp_cur + TWO;
        addr1   = sp_cur + ONE;
        sp_step = sp_cur + TWO;
        en      = 1'b1;
        pair    = 1'b1;
      end
      default: ;                // R9: idle or undefined code
    endcase
  end
endmodule

// File: rtl/sp_bus_port.sv
module sp_bus_port #(
  parameter int              IMPL_W  = 12,
  parameter int              DATA_W  = 8,
  parameter int              BUS_AW  = 16,
  parameter logic [BUS_AW-1:0] LO_ADDR = 16'h005D
) (
  input  logic [BUS_AW-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_we,
  input  logic [IMPL_W-1:0]  sp_cur,
  output logic [DATA_W-1:0]  rdata,
  output logic               wr_hit,
  output logic [IMPL_W-1:0]  wr_val
);
  localparam logic [BUS_AW-1:0] HI_ADDR = LO_ADDR + BUS_AW'(1);
  localparam int                HI_BITS = IMPL_W - DATA_W;

  logic hit_lo, hit_hi;

  assign hit_lo = (bus_addr == LO_ADDR);
  assign hit_hi = (bus_addr == HI_ADDR);
  assign wr_hit = bus_we && (hit_lo || hit_hi);

  // R7/R9: read mux, unimplemented high bits padded with zero (R6)
  always_comb begin
    rdata = '0;
    if (hit_lo)      rdata = sp_cur[DATA_W-1:0];
    else if (hit_hi) rdata = {{(2*DATA_W-IMPL_W){1'b0}}, sp_cur[IMPL_W-1:DATA_W]};
  end

  // R6/R7: only the implemented bits of the high byte are loaded
  always_comb begin
    if (hit_lo) wr_val = {sp_cur[IMPL_W-1:DATA_W], bus_wdata};
    else        wr_val = {bus_wdata[HI_BITS-1:0], sp_cur[DATA_W-1:0]};
  end
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit #(
  parameter int              SP_W      = 16,
  parameter int              IMPL_W    = 12,
  parameter int              DATA_W    = 8,
  parameter int              BUS_AW    = 16,
  parameter logic [SP_W-1:0] RESET_VAL = 16'h04FF,
  parameter logic [BUS_AW-1:0] LO_ADDR = 16'h005D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [SP_W-1:0]   sp,
  output logic [SP_W-1:0]   acc_addr0,
  output logic [SP_W-1:0]   acc_addr1,
  output logic              acc_en,
  output logic              acc_wr,
  output logic              acc_pair
);
  import sp_pkg::*;

  localparam int                PAD      = SP_W - IMPL_W;
  localparam logic [IMPL_W-1:0] RST_IMPL = RESET_VAL[IMPL_W-1:0];

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ok   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ok   <= rst_meta;
    end
  end

  logic [IMPL_W-1:0] sp_q, sp_d, step_val, wr_val, a0, a1;
  logic              wr_hit, sp_ld;
  sp_op_e            op_e;

  assign op_e = sp_op_e'(op);

  sp_adjust #(.IMPL_W(IMPL_W)) u_adjust (
    .op_i   (op_e),
    .sp_cur (sp_q),
    .sp_step(step_val),
    .addr0  (a0),
    .addr1  (a1),
    .en     (acc_en),
    .wr     (acc_wr),
    .pair   (acc_pair)
  );

  sp_bus_port #(
    .IMPL_W (IMPL_W),
    .DATA_W (DATA_W),
    .BUS_AW (BUS_AW),
    .LO_ADDR(LO_ADDR)
  ) u_bus (
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_we   (bus_we),
    .sp_cur   (sp_q),
    .rdata    (bus_rdata),
    .wr_hit   (wr_hit),
    .wr_val   (wr_val)
  );

  // Next state: bus write wins over a stack step (R8)
  always_comb begin
    sp_ld = wr_hit || acc_en;
    sp_d  = wr_hit ? wr_val : step_val;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok)    sp_q <= RST_IMPL;
    else if (sp_ld) sp_q <= sp_d;
  end

  assign sp        = {{PAD{1'b0}}, sp_q};
  assign acc_addr0 = {{PAD{1'b0}}, a0};
  assign acc_addr1 = {{PAD{1'b0}}, a1};

  // ---------------- assertions ----------------
  localparam logic [SP_W-1:0] MASK = {{PAD{1'b0}}, {IMPL_W{1'b1}}};

  a_r2_push_step: assert property (@(posedge clk) disable iff (!rst_ok)
    (op == 3'd1 && !wr_hit) |=> sp == (($past(sp) - SP_W'(1)) & MASK));
  a_r3_pop_step: assert property (@(posedge clk) disable iff (!rst_ok)
    (op == 3'd2 && !wr_hit) |=> sp == (($past(sp) + SP_W'(1)) & MASK));
  a_r4_call_step: assert property (@(posedge clk) disable iff (!rst_ok)
    (op == 3'd3 && !wr_hit) |=> sp == (($past(sp) - SP_W'(2)) & MASK));
  a_r5_ret_step: assert property (@(posedge clk) disable iff (!rst_ok)
    (op == 3'd4 && !wr_hit) |=> sp == (($past(sp) + SP_W'(2)) & MASK));
  a_r4_pair_adjacent: assert property (@(posedge clk) disable iff (!rst_ok)
    (acc_pair && acc_wr) |-> acc_addr1 == ((acc_addr0 - SP_W'(1)) & MASK));
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_ok)
    sp[SP_W-1:IMPL_W] == '0);
  a_r8_lo_write_wins: assert property (@(posedge clk) disable iff (!rst_ok)
    (bus_we && bus_addr == LO_ADDR) |=> sp[DATA_W-1:0] == $past(bus_wdata));
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_ok)
    (!acc_en && !wr_hit) |=> $stable(sp));
endmodule

// File: tb/stack_ptr_unit_test.sv
module stack_ptr_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  op;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_we;
  logic [7:0]  bus_rdata;
  logic [15:0] sp, acc_addr0, acc_addr1;
  logic        acc_en, acc_wr, acc_pair;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;  // 50 MHz

  stack_ptr_unit uut (
    .clk(clk), .rst_n(rst_n), .op(op), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
    .sp(sp), .acc_addr0(acc_addr0), .acc_addr1(acc_addr1),
    .acc_en(acc_en), .acc_wr(acc_wr), .acc_pair(acc_pair)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    check(act === exp, tag, int'(act), int'(exp));
  endtask

  // Drive one cycle's inputs on the falling edge; settle combinational outputs.
  task automatic apply(input logic [2:0] o, input logic [15:0] a, input logic [7:0] d, input logic we);
    @(negedge clk);
    op = o; bus_addr = a; bus_wdata = d; bus_we = we;
    #1;
  endtask

  task automatic idle();
    apply(3'd0, 16'h0000, 8'h00, 1'b0);
  endtask

  task automatic load_sp(input logic [15:0] v);
    apply(3'd0, 16'h005D, v[7:0], 1'b1);
    apply(3'd0, 16'h005E, v[15:8], 1'b1);
    idle();
  endtask

  task automatic t_reset();
    idle();
    chk16("R1 reset sp", sp, 16'h04FF);
    check(acc_en === 1'b0, "R1 acc_en idle", int'(acc_en), 0);
    apply(3'd0, 16'h005D, 8'h00, 1'b0);
    chk16("R7 read lo", {8'h0, bus_rdata}, 16'h00FF);
    apply(3'd0, 16'h005E, 8'h00, 1'b0);
    chk16("R7 read hi", {8'h0, bus_rdata}, 16'h0004);
  endtask

  task automatic t_push_pop();
    apply(3'd1, 16'h0, 8'h0, 1'b0);
    chk16("R2 push addr", acc_addr0, 16'h04FF);
    check(acc_wr === 1'b1 && acc_pair === 1'b0, "R2 push wr", int'({acc_wr, acc_pair}), 2);
    apply(3'd1, 16'h0, 8'h0, 1'b0);
    chk16("R2 b2b push sp", sp, 16'h04FE);
    chk16("R2 b2b push addr", acc_addr0, 16'h04FE);
    idle();
    chk16("R2 sp after 2 pushes", sp, 16'h04FD);
    apply(3'd2, 16'h0, 8'h0, 1'b0);
    chk16("R3 pop addr", acc_addr0, 16'h04FE);
    check(acc_wr === 1'b0 && acc_en === 1'b1, "R3 pop rd", int'({acc_en, acc_wr}), 2);
    idle();
    chk16("R3 pop sp", sp, 16'h04FE);
  endtask

  task automatic t_call_ret();
    apply(3'd3, 16'h0, 8'h0, 1'b0);
    chk16("R4 call lo addr", acc_addr0, 16'h04FE);
    chk16("R4 call hi addr", acc_addr1, 16'h04FD);
    check(acc_wr === 1'b1 && acc_pair === 1'b1, "R4 call flags", int'({acc_wr, acc_pair}), 3);
    idle();
    chk16("R4 call sp", sp, 16'h04FC);
    apply(3'd4, 16'h0, 8'h0, 1'b0);
    chk16("R5 ret lo addr", acc_addr0, 16'h04FE);
    chk16("R5 ret hi addr", acc_addr1, 16'h04FD);
    check(acc_wr === 1'b0 && acc_pair === 1'b1, "R5 ret flags", int'({acc_wr, acc_pair}), 1);
    idle();
    chk16("R5 ret sp", sp, 16'h04FE);
  endtask

  task automatic t_bus_write();
    apply(3'd0, 16'h005D, 8'h34, 1'b1);
    chk16("R7 no change before edge", sp, 16'h04FE);
    idle();
    chk16("R7 lo write", sp, 16'h0434);
    apply(3'd0, 16'h005E, 8'hF7, 1'b1);
    idle();
    chk16("R6 hi write masked", sp, 16'h0734);
    apply(3'd0, 16'h005E, 8'h00, 1'b0);
    chk16("R6 hi read upper zero", {8'h0, bus_rdata}, 16'h0007);
  endtask

  task automatic t_priority();
    apply(3'd1, 16'h005D, 8'h80, 1'b1);
    idle();
    chk16("R8 write beats push", sp, 16'h0780);
    apply(3'd4, 16'h005E, 8'h02, 1'b1);
    idle();
    chk16("R8 write beats ret", sp, 16'h0280);
  endtask

  task automatic t_wrap();
    load_sp(16'h0000);
    chk16("R6 loaded zero", sp, 16'h0000);
    apply(3'd1, 16'h0, 8'h0, 1'b0);
    chk16("R6 push addr at 0", acc_addr0, 16'h0000);
    idle();
    chk16("R6 push wraps", sp, 16'h0FFF);
    apply(3'd2, 16'h0, 8'h0, 1'b0);
    chk16("R6 pop addr wraps", acc_addr0, 16'h0000);
    idle();
    chk16("R6 pop wraps", sp, 16'h0000);
    load_sp(16'h0001);
    apply(3'd3, 16'h0, 8'h0, 1'b0);
    chk16("R6 call hi addr", acc_addr1, 16'h0000);
    idle();
    chk16("R6 call wraps", sp, 16'h0FFF);
    apply(3'd4, 16'h0, 8'h0, 1'b0);
    chk16("R6 ret lo addr wraps", acc_addr0, 16'h0001);
    chk16("R6 ret hi addr wraps", acc_addr1, 16'h0000);
    idle();
    chk16("R6 ret wraps", sp, 16'h0001);
  endtask

  task automatic t_ignored();
    load_sp(16'h0123);
    apply(3'd0, 16'h005C, 8'h11, 1'b1);
    chk16("R9 other addr reads 0", {8'h0, bus_rdata}, 16'h0000);
    apply(3'd0, 16'h005F, 8'h22, 1'b1);
    idle();
    chk16("R9 other addr write ignored", sp, 16'h0123);
    apply(3'd6, 16'h0, 8'h0, 1'b0);
    check(acc_en === 1'b0, "R9 undefined op no access", int'(acc_en), 0);
    idle();
    idle();
    chk16("R9 hold", sp, 16'h0123);
  endtask

  initial begin
    rst_n = 1'b0;
    op = 3'd0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_push_pop();
    t_call_ret();
    t_bus_write();
    t_priority();
    t_wrap();
    t_ignored();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule